// File: doc/BRIEF.md
# IDE PIO Cycle Timing Controller

This block runs programmed-I/O register and data cycles on one legacy IDE channel that carries two drives. A host-side request (I/O address, direction, write data) is decoded against the channel's eight command ports and its single control/alternate-status port. A decoded request becomes a complete drive cycle: chip select and device address during setup, a read or write strobe, optional extension by IORDY, and a recovery gap. Read data comes back with a one-clock done pulse.

A 16-bit timing word sets the cycle shape. It holds a channel enable, a primary/secondary select, one control nibble per drive, and one fast timing set that both drives share. A drive uses the fast set only when its nibble opts in; otherwise it runs slow compatible timing. A drive whose nibble allows posting has its data-port writes acknowledged at once. The drive cycle then runs in the background.

Top module: `ide_pio_timer`

## Requirements
- R1: While cfg_i bit 15 is 0, no address decodes. An accepted request drives no chip select or strobe, gives done_o one clock after acceptance with rdata_o = 0, and leaves req_ready_o high.
- R2: cfg_i bit 14 = 0 maps command ports 0x1F0..0x1F7 and control port 0x3F6; bit 14 = 1 maps 0x170..0x177 and 0x376. A command port asserts ide_cs0_no with ide_da_o = address bits 2:0. The control port asserts ide_cs1_no with ide_da_o = 6. Any other address behaves as in R1.
- R3: An accepted write to command offset 6 stores write-data bit 4 as the current drive. The current drive picks that drive's nibble at cfg_i bits [4*drive+3 : 4*drive] for every later cycle. The write itself uses the drive stored before it.
- R4: When nibble bit 0 of the current drive is 0, a cycle has 3 clocks of setup (chip select, no strobe), 9 clocks of strobe and 8 clocks of recovery. req_ready_o returns high after recovery.
- R5: When nibble bit 0 is 1, a cycle has 1 setup clock. The strobe lasts cfg_i[13:12]+2 clocks and recovery lasts cfg_i[9:8]+1 clocks.
- R6: When nibble bit 1 is 1 and ide_iordy_i is low at the last planned strobe clock, the strobe is held until a clock edge sees ide_iordy_i high. When nibble bit 1 is 0, ide_iordy_i has no effect.
- R7: After TMO_CLKS extension clocks without IORDY, the strobe ends and err_o goes high. err_o stays high until reset.
- R8: When nibble bit 2 is 1, a write to command offset 0 has done_o one clock after acceptance. req_ready_o stays low until that cycle's recovery ends. Writes to other offsets are not posted.
- R9: For non-posted cycles, done_o pulses in the first recovery clock. A read returns in rdata_o the ide_dd_i value present at the clock edge that ends the strobe. A write drives ide_dd_o with ide_dd_oe_o high from the first setup clock to the end of the strobe.
- R10: After reset no chip select or strobe is active, req_ready_o is high, and done_o and err_o are low. A request is accepted only while req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 16 | Timing/control word |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 10 | Host I/O address |
| req_wdata_i | input | 16 | Host write data |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read data, valid with done_o |
| err_o | output | 1 | Sticky IORDY timeout flag |
| ide_cs0_no | output | 1 | Command-block chip select, active low |
| ide_cs1_no | output | 1 | Control-block chip select, active low |
| ide_da_o | output | 3 | Device address |
| ide_dior_no | output | 1 | Read strobe, active low |
| ide_diow_no | output | 1 | Write strobe, active low |
| ide_dd_o | output | 16 | Drive data out |
| ide_dd_oe_o | output | 1 | Drive data output enable |
| ide_dd_i | input | 16 | Drive data in |
| ide_iordy_i | input | 1 | Drive ready |

## Verification
The bench builds the block with TMO_CLKS = 16 instead of 256. This puts an IORDY timeout and the sticky error within a few dozen clocks. Address and data widths stay at 10 and 16, so the bench can drive the real legacy port numbers for both channel selections. The compatible-timing defaults stay as they are, so the 3/9/8 cycle shape is checked exactly.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  localparam int TCNT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_WAIT,
    ST_RECOV
  } cyc_state_e;

  typedef struct packed {
    logic [TCNT_W-1:0] setup;
    logic [TCNT_W-1:0] active;
    logic [TCNT_W-1:0] recov;
    logic              iordy_en;
    logic              post_en;
  } timing_t;

  typedef struct packed {
    logic       hit;
    logic       ctl;
    logic [2:0] da;
  } decode_t;
endpackage

// File: rtl/ide_port_decode.sv
module ide_port_decode
  import ide_pio_pkg::*;
#(
  parameter int              ADDR_W  = 10,
  parameter logic [ADDR_W-1:0] PRI_CMD = 10'h1F0,
  parameter logic [ADDR_W-1:0] PRI_CTL = 10'h3F6,
  parameter logic [ADDR_W-1:0] SEC_CMD = 10'h170,
  parameter logic [ADDR_W-1:0] SEC_CTL = 10'h376
) (
  input  logic              en_i,
  input  logic              sec_i,
  input  logic [ADDR_W-1:0] addr_i,
  output decode_t           dec_o
);
  logic [ADDR_W-1:0] cmd_base, ctl_port;
  logic              cmd_hit, ctl_hit;

  assign cmd_base = sec_i ? SEC_CMD : PRI_CMD;
  assign ctl_port = sec_i ? SEC_CTL : PRI_CTL;
  assign cmd_hit  = (addr_i[ADDR_W-1:3] == cmd_base[ADDR_W-1:3]);
  assign ctl_hit  = (addr_i == ctl_port);

  always_comb begin
    dec_o.hit = en_i && (cmd_hit || ctl_hit);
    dec_o.ctl = ctl_hit && !cmd_hit;
    dec_o.da  = dec_o.ctl ? 3'd6 : addr_i[2:0];
  end
endmodule

// File: rtl/ide_timing_sel.sv
module ide_timing_sel
  import ide_pio_pkg::*;
#(
  parameter int NUM_DRV       = 2,
  parameter int COMPAT_SETUP  = 3,
  parameter int COMPAT_ACTIVE = 9,
  parameter int COMPAT_RECOV  = 8,
  parameter int FAST_SETUP    = 1,
  localparam int DRV_W        = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  logic [15:0]      cfg_i,
  input  logic [DRV_W-1:0] drive_i,
  output timing_t          tm_o
);
  logic [3:0] nib [NUM_DRV];
  logic [3:0] sel;

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_nib
    assign nib[g] = cfg_i[4*g +: 4];
  end

  assign sel = nib[drive_i];

  always_comb begin
    if (sel[0]) begin
      tm_o.setup  = TCNT_W'(FAST_SETUP);
      tm_o.active = TCNT_W'(cfg_i[13:12]) + TCNT_W'(2);
      tm_o.recov  = TCNT_W'(cfg_i[9:8]) + TCNT_W'(1);
    end else begin
      tm_o.setup  = TCNT_W'(COMPAT_SETUP);
      tm_o.active = TCNT_W'(COMPAT_ACTIVE);
      tm_o.recov  = TCNT_W'(COMPAT_RECOV);
    end
    tm_o.iordy_en = sel[1];
    tm_o.post_en  = sel[2];
  end
endmodule

// File: rtl/ide_cycle_fsm.sv
module ide_cycle_fsm
  import ide_pio_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int TMO_CLKS = 256,
  localparam int WCNT_W  = $clog2(TMO_CLKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  decode_t           dec_i,
  input  timing_t           tm_i,
  input  logic              write_i,
  input  logic              post_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              cs0_no,
  output logic              cs1_no,
  output logic [2:0]        da_o,
  output logic              dior_no,
  output logic              diow_no,
  output logic [DATA_W-1:0] dd_o,
  output logic              dd_oe_o,
  input  logic [DATA_W-1:0] dd_i,
  input  logic              iordy_i
);
  cyc_state_e        state_q;
  logic [TCNT_W-1:0] cnt_q;
  logic [WCNT_W-1:0] wcnt_q;
  timing_t           tm_q;
  logic              wr_q, ctl_q, post_q, done_q, err_q;
  logic [2:0]        da_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              wcnt_hit, strobe_end, tmo, in_cs, in_strobe;

  assign wcnt_hit = (wcnt_q == WCNT_W'(TMO_CLKS));
  assign tmo      = (state_q == ST_WAIT) && !iordy_i && wcnt_hit;

  always_comb begin
    strobe_end = 1'b0;
    if (state_q == ST_ACTIVE && cnt_q == '0)
      strobe_end = !(tm_q.iordy_en && !iordy_i);
    else if (state_q == ST_WAIT)
      strobe_end = iordy_i || wcnt_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wcnt_q  <= '0;
      tm_q    <= '0;
      wr_q    <= 1'b0;
      ctl_q   <= 1'b0;
      post_q  <= 1'b0;
      da_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tmo) err_q <= 1'b1;
      if (strobe_end) begin
        state_q <= ST_RECOV;
        cnt_q   <= tm_q.recov - 1'b1;
        if (!post_q) begin
          done_q  <= 1'b1;
          rdata_q <= wr_q ? '0 : dd_i;
        end
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (start_i) begin
              if (!dec_i.hit) begin
                done_q  <= 1'b1;
                rdata_q <= '0;
              end else begin
                state_q <= ST_SETUP;
                cnt_q   <= tm_i.setup - 1'b1;
                tm_q    <= tm_i;
                wr_q    <= write_i;
                ctl_q   <= dec_i.ctl;
                da_q    <= dec_i.da;
                wdata_q <= wdata_i;
                post_q  <= post_i;
                done_q  <= post_i;
              end
            end
          end
          ST_SETUP: begin
            if (cnt_q == '0) begin
              state_q <= ST_ACTIVE;
              cnt_q   <= tm_q.active - 1'b1;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          ST_ACTIVE: begin
            if (cnt_q == '0) begin
              state_q <= ST_WAIT;
              wcnt_q  <= WCNT_W'(1);
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          ST_WAIT: wcnt_q <= wcnt_q + 1'b1;
          ST_RECOV: begin
            if (cnt_q == '0) state_q <= ST_IDLE;
            else             cnt_q   <= cnt_q - 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign in_cs     = (state_q == ST_SETUP) || (state_q == ST_ACTIVE) || (state_q == ST_WAIT);
  assign in_strobe = (state_q == ST_ACTIVE) || (state_q == ST_WAIT);

  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
  assign err_o   = err_q;
  assign cs0_no  = !(in_cs && !ctl_q);
  assign cs1_no  = !(in_cs && ctl_q);
  assign da_o    = da_q;
  assign dior_no = !(in_strobe && !wr_q);
  assign diow_no = !(in_strobe && wr_q);
  assign dd_o    = wdata_q;
  assign dd_oe_o = in_cs && wr_q;

  a_r4_strobe_in_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dior_no || !diow_no) |-> (!cs0_no || !cs1_no));
  a_r5_min_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dior_no && diow_no) |=> !(dior_no && diow_no));
  a_r6_min_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dior_no && diow_no) |=> (dior_no && diow_no));
  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r9_oe_not_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dd_oe_o |-> dior_no);
endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
  import ide_pio_pkg::*;
#(
  parameter int ADDR_W        = 10,
  parameter int DATA_W        = 16,
  parameter int NUM_DRV       = 2,
  parameter int COMPAT_SETUP  = 3,
  parameter int COMPAT_ACTIVE = 9,
  parameter int COMPAT_RECOV  = 8,
  parameter int FAST_SETUP    = 1,
  parameter int TMO_CLKS      = 256,
  localparam int DRV_W        = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cfg_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              ide_cs0_no,
  output logic              ide_cs1_no,
  output logic [2:0]        ide_da_o,
  output logic              ide_dior_no,
  output logic              ide_diow_no,
  output logic [DATA_W-1:0] ide_dd_o,
  output logic              ide_dd_oe_o,
  input  logic [DATA_W-1:0] ide_dd_i,
  input  logic              ide_iordy_i
);
  decode_t          dec;
  timing_t          tm;
  logic [DRV_W-1:0] drive_q;
  logic             start, post, drv_wr;

  ide_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .en_i  (cfg_i[15]),
    .sec_i (cfg_i[14]),
    .addr_i(req_addr_i),
    .dec_o (dec)
  );

  ide_timing_sel #(
    .NUM_DRV      (NUM_DRV),
    .COMPAT_SETUP (COMPAT_SETUP),
    .COMPAT_ACTIVE(COMPAT_ACTIVE),
    .COMPAT_RECOV (COMPAT_RECOV),
    .FAST_SETUP   (FAST_SETUP)
  ) u_tsel (
    .cfg_i  (cfg_i),
    .drive_i(drive_q),
    .tm_o   (tm)
  );

  assign start  = req_valid_i && req_ready_o;
  assign post   = tm.post_en && req_write_i && dec.hit && !dec.ctl && (dec.da == 3'd0);
  assign drv_wr = start && req_write_i && dec.hit && !dec.ctl && (dec.da == 3'd6);

  // drive/head register shadow: bit 4 of the written byte picks the drive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     drive_q <= '0;
    else if (drv_wr) drive_q <= DRV_W'(req_wdata_i[4]);
  end

  ide_cycle_fsm #(.DATA_W(DATA_W), .TMO_CLKS(TMO_CLKS)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .dec_i  (dec),
    .tm_i   (tm),
    .write_i(req_write_i),
    .post_i (post),
    .wdata_i(req_wdata_i),
    .ready_o(req_ready_o),
    .done_o (done_o),
    .rdata_o(rdata_o),
    .err_o  (err_o),
    .cs0_no (ide_cs0_no),
    .cs1_no (ide_cs1_no),
    .da_o   (ide_da_o),
    .dior_no(ide_dior_no),
    .diow_no(ide_diow_no),
    .dd_o   (ide_dd_o),
    .dd_oe_o(ide_dd_oe_o),
    .dd_i   (ide_dd_i),
    .iordy_i(ide_iordy_i)
  );

  a_r1_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !cfg_i[15]) |=> (ide_cs0_no && ide_cs1_no && req_ready_o));
endmodule

// File: tb/ide_pio_timer_tb.sv
module ide_pio_timer_tb_top;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg = 16'h8000;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [15:0] req_wdata = '0, dd_in = '0;
  logic        iordy = 1'b1;
  logic        ready, done, err, cs0_n, cs1_n, dior_n, diow_n, dd_oe;
  logic [15:0] rdata, dd_out;
  logic [2:0]  da;

  int n_tests = 0, n_fail = 0;
  int drv_m = 0;
  bit err_m = 0;

  always #5 clk = ~clk;

  ide_pio_timer #(.TMO_CLKS(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg),
    .req_valid_i(req_valid), .req_ready_o(ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .done_o(done), .rdata_o(rdata), .err_o(err),
    .ide_cs0_no(cs0_n), .ide_cs1_no(cs1_n), .ide_da_o(da),
    .ide_dior_no(dior_n), .ide_diow_no(diow_n),
    .ide_dd_o(dd_out), .ide_dd_oe_o(dd_oe), .ide_dd_i(dd_in), .ide_iordy_i(iordy)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // One host request, compared against the model on every clock.
  task automatic xfer(input logic wr, input logic [9:0] a, input logic [15:0] wd,
                      input int low_clks, input string rq);
    int base, ctlp, nib, s, act, r, phase, end_k, mism, k, strobe_cnt;
    bit hit, is_ctl, en_io, posted, fast, io_next, done_exp, seen_rd;
    logic [2:0] da_e;
    logic [15:0] rd_pat;
    base = cfg[14] ? 'h170 : 'h1F0;
    ctlp = cfg[14] ? 'h376 : 'h3F6;
    is_ctl = (a == ctlp);
    hit = cfg[15] && (is_ctl || (a >= base && a <= base + 7));
    da_e = is_ctl ? 3'd6 : a[2:0];
    nib = (cfg >> (4 * drv_m)) & 'hF;
    fast = nib[0];
    s   = fast ? 1 : 3;
    act = fast ? int'(cfg[13:12]) + 2 : 9;
    r   = fast ? int'(cfg[9:8]) + 1 : 8;
    en_io = nib[1];
    posted = nib[2] && wr && hit && !is_ctl && (da_e == 3'd0);
    rd_pat = {a[7:0], 8'h3C} ^ 16'h5A00;
    @(negedge clk);
    dd_in = rd_pat;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    iordy = (low_clks == 0);
    @(negedge clk);
    req_valid = 1'b0;
    if (!hit) begin
      chk(done && rdata == 0 && cs0_n && cs1_n && dior_n && diow_n && ready,
          rq, "unmapped request completes at once", {done, cs0_n, cs1_n, ready}, 4'b1111);
      return;
    end
    mism = 0; phase = 0; end_k = 0; strobe_cnt = 0; seen_rd = 0;
    for (k = 1; k < 1000; k++) begin
      done_exp = posted ? (k == 1) : (phase == 2 && k == end_k + 1);
      if (cs0_n !== !(phase < 2 && !is_ctl)) mism++;
      if (cs1_n !== !(phase < 2 && is_ctl)) mism++;
      if (dior_n !== !(phase == 1 && !wr)) mism++;
      if (diow_n !== !(phase == 1 && wr)) mism++;
      if (ready !== 1'b0) mism++;
      if (done !== done_exp) mism++;
      if (phase < 2 && da !== da_e) mism++;
      if (phase < 2 && wr && (dd_oe !== 1'b1 || dd_out !== wd)) mism++;
      if (!wr && dd_oe !== 1'b0) mism++;
      if (!dior_n || !diow_n) strobe_cnt++;
      if (done_exp && !wr) begin
        seen_rd = 1;
        chk(rdata == rd_pat, "R9", "read data", rdata, rd_pat);
      end
      io_next = (k >= s + act + low_clks);
      iordy = io_next;
      if (phase == 0 && k == s) phase = 1;
      else if (phase == 1 && k >= s + act &&
               (!en_io || io_next || (k - (s + act)) == TMO)) begin
        if (en_io && !io_next) err_m = 1;
        phase = 2; end_k = k;
      end else if (phase == 2 && k == end_k + r) break;
      @(negedge clk);
    end
    @(negedge clk);
    iordy = 1'b1;
    if (ready !== 1'b1) mism++;
    chk(mism == 0, rq, "cycle shape mismatches", mism, 0);
    chk(strobe_cnt == end_k - s, rq, "strobe width", strobe_cnt, end_k - s);
    chk(err == err_m, "R7", "error flag", err, err_m);
    if (!wr && !posted) chk(seen_rd, "R9", "read done seen", seen_rd, 1);
    if (wr && hit && !is_ctl && da_e == 3'd6) drv_m = wd[4];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs0_n && cs1_n && dior_n && diow_n && !done && !err && ready,
        "R10", "reset state", {cs0_n, cs1_n, dior_n, diow_n, done, err, ready}, 7'b1111001);
    rst_n = 1'b1;
    // R4 compatible timing, R2 primary decode, R9 read data
    xfer(0, 10'h1F7, 0, 0, "R4");
    xfer(1, 10'h1F2, 16'hBEEF, 0, "R9");
    xfer(0, 10'h3F6, 0, 0, "R2");
    xfer(0, 10'h170, 0, 0, "R2");
    xfer(0, 10'h376, 0, 0, "R2");
    // secondary channel
    cfg = 16'hC000;
    xfer(0, 10'h172, 0, 0, "R2");
    xfer(0, 10'h376, 0, 0, "R2");
    xfer(0, 10'h1F2, 0, 0, "R2");
    xfer(0, 10'h3F6, 0, 0, "R2");
    // channel disabled
    cfg = 16'h4000;
    xfer(0, 10'h172, 0, 0, "R1");
    cfg = 16'h0000;
    xfer(1, 10'h1F0, 16'h1234, 0, "R1");
    // fast timing sets, drive 0 opted in
    cfg = 16'h8001;
    xfer(0, 10'h1F0, 0, 0, "R5");
    cfg = 16'h9001;
    xfer(0, 10'h1F1, 0, 0, "R5");
    cfg = 16'hA101;
    xfer(1, 10'h1F3, 16'h00A5, 0, "R5");
    cfg = 16'hA301;
    xfer(0, 10'h1F0, 0, 0, "R5");
    // drive select: drive 1 not opted in
    xfer(1, 10'h1F6, 16'h0010, 0, "R3");
    xfer(0, 10'h1F0, 0, 0, "R3");
    cfg = 16'hA311;
    xfer(0, 10'h1F0, 0, 0, "R3");
    xfer(1, 10'h1F6, 16'h0000, 0, "R3");
    cfg = 16'hA301;
    xfer(0, 10'h1F0, 0, 0, "R3");
    // IORDY ignored, then honoured
    xfer(0, 10'h1F0, 0, 5, "R6");
    cfg = 16'hA303;
    xfer(0, 10'h1F0, 0, 5, "R6");
    cfg = 16'h8002;
    xfer(1, 10'h1F0, 16'h7788, 3, "R6");
    // timeout
    cfg = 16'h9003;
    xfer(0, 10'h1F7, 0, 100, "R7");
    xfer(0, 10'h1F7, 0, 0, "R7");
    // posting
    cfg = 16'hA305;
    xfer(1, 10'h1F0, 16'hCAFE, 0, "R8");
    xfer(1, 10'h1F1, 16'h0042, 0, "R8");
    cfg = 16'h8004;
    xfer(1, 10'h1F0, 16'hF00D, 0, "R8");
    xfer(0, 10'h1F0, 0, 0, "R8");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule